// File: doc/BRIEF.md
# Receive Byte Queue with Batched Interrupt

This block stores received serial frames between a receiver's frame output and a processor read port. The processor is interrupted once per batch instead of once per frame. Frames enter as 8-bit words on a valid/ready input and are held in a 16-entry first-in first-out store. The processor takes them from a valid/ready read side whose data is the oldest stored frame.

The single interrupt line rises when the fill level reaches a programmable threshold. It then stays high until the store is completely empty, so one service routine can drain every frame. An idle timer stops a small remainder from waiting forever. The timer is reloaded on every accepted frame and on every read. If it runs out while frames are still stored, it raises the interrupt even though the level is below the threshold.

Back-pressure rules: the receiver cannot be stalled. `rx_ready` is only advisory. A frame offered while the store is full is dropped unless a read takes place in the same cycle. A dropped frame sets the sticky overrun flag. On the read side, `rd_valid` is high whenever the store is not empty. A frame is removed on a clock edge where both `rd_valid` and `rd_ready` are high. Asserting `rd_ready` while `rd_valid` is low has no effect.

Top module: `rxq_thresh_fifo`

## Requirements
- R1: The store holds up to 16 frames and returns them in arrival order. `fill_level` counts from 0 to 16. `empty` is high exactly when the level is 0. `rx_ready` is high when the level is below 16.
- R2: `thr_sel` encodes the threshold as follows: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. With the idle timer disabled, `rx_irq` stays low while the level is nonzero but below the threshold. It rises on the clock edge at which the level reaches the threshold.
- R3: Once high, `rx_irq` stays high while the level falls below the threshold. It falls on the same edge at which the level becomes 0. It is never high while `empty` is high.
- R4: The idle timer holds the value `idle_reload`. With frames stored and no accepted write or read, `rx_irq` rises exactly `idle_reload` cycles after the edge of the last accepted write or read. Every accepted write and every accepted read reloads the timer.
- R5: An `idle_reload` of 0 disables the idle timeout. The timer is held cleared while the store is empty, so it never raises the interrupt with no frames stored.
- R6: With threshold code 0, `rx_irq` equals the inverse of `empty` at all times, as with a one-register receiver.
- R7: A frame offered while the store is full and no read occurs is discarded. In that case the level and the stored contents are unchanged, and `overrun` is set on the next edge.
- R8: `overrun` stays set until `ovr_clr` is pulsed. If a new drop and `ovr_clr` happen in the same cycle, the flag stays set.
- R9: An accepted write and an accepted read in the same cycle leave the level unchanged, and both take effect. When the store is full, a frame offered together with a read is accepted, and `overrun` is not set.
- R10: Changing `thr_sel` while `rx_irq` is high does not lower `rx_irq`.
- R11: `rd_data` shows the oldest stored frame combinationally, in the same cycle as the write edge that stored it into an empty store. A read while empty leaves the level at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receiver offers a frame this cycle |
| rx_data | input | 8 | Offered frame |
| rx_ready | output | 1 | A frame offered now would be stored |
| rd_valid | output | 1 | A frame is available at rd_data |
| rd_ready | input | 1 | Processor takes the head frame |
| rd_data | output | 8 | Oldest stored frame |
| thr_sel | input | 2 | Threshold code (0:1, 1:4, 2:8, 3:14) |
| idle_reload | input | 16 | Idle timeout in cycles, 0 disables it |
| ovr_clr | input | 1 | Clears the overrun flag |
| fill_level | output | 5 | Number of stored frames |
| empty | output | 1 | Store holds no frame |
| overrun | output | 1 | Sticky flag that a frame was dropped |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The hardest case to reach is the idle timeout at its exact cycle. The timeout has to fire with frames stored below the threshold. It also must not fire when new frames keep arriving just before it runs out. The stimulus first stores two frames under threshold 14 and counts cycles from the last accepted edge to the rise of the interrupt. It then refills the store at intervals shorter than the reload value, which must never let the timer expire. A full store with a concurrent read and a new frame is also forced on purpose. This case shows that a drop is decided by the read on the same edge and not by the full flag alone.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Threshold code: 0 -> 1, 1 -> depth/4, 2 -> depth/2, 3 -> depth-2
  function automatic int unsigned thr_value(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic              push_ok,
  output logic              push_fire,
  output logic              pop_fire,
  output logic [DATA_W-1:0] head_data,
  output logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  level_nxt,
  output logic              is_empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              is_full;

  assign is_full   = (level == LVL_W'(DEPTH));
  assign is_empty  = (level == '0);
  assign pop_fire  = pop_req && !is_empty;
  assign push_ok   = !is_full || pop_req;
  assign push_fire = push_req && (!is_full || pop_fire);
  assign head_data = mem[rptr];

  always_comb begin
    case ({push_fire, pop_fire})
      2'b10:   level_nxt = level + LVL_W'(1);
      2'b01:   level_nxt = level - LVL_W'(1);
      default: level_nxt = level;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push_fire) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_fire) wptr <= wptr + AW'(1);
      if (pop_fire)  rptr <= rptr + AW'(1);
      level <= level_nxt;
    end
  end
endmodule

// File: rtl/rxq_idle_tmr.sv
module rxq_idle_tmr #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             activity,
  input  logic             occupied,
  input  logic             hold_clear,
  input  logic [TMR_W-1:0] reload,
  output logic             expire
);
  logic [TMR_W-1:0] cnt;

  assign expire = occupied && !activity && (cnt == TMR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (hold_clear)      cnt <= '0;
    else if (activity)        cnt <= reload;
    else if (cnt != '0)       cnt <= cnt - TMR_W'(1);
  end
endmodule

// File: rtl/rxq_irq_ctrl.sv
module rxq_irq_ctrl #(
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       thr_sel,
  input  logic [LVL_W-1:0] level_nxt,
  input  logic             expire,
  output logic             irq
);
  logic [LVL_W-1:0] thr_lvl;

  assign thr_lvl = LVL_W'(rxq_pkg::thr_value(thr_sel, DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                irq <= 1'b0;
    else if (level_nxt == '0)                  irq <= 1'b0;
    else if (level_nxt >= thr_lvl || expire)   irq <= 1'b1;
  end
endmodule

// File: rtl/rxq_thresh_fifo.sv
module rxq_thresh_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int TMR_W  = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        thr_sel,
  input  logic [TMR_W-1:0]  idle_reload,
  input  logic              ovr_clr,
  output logic [LVL_W-1:0]  fill_level,
  output logic              empty,
  output logic              overrun,
  output logic              rx_irq
);
  logic             push_fire, pop_fire, push_ok, expire;
  logic [LVL_W-1:0] level_nxt;
  logic             ovr_q;

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (rx_valid),
    .push_data (rx_data),
    .pop_req   (rd_ready),
    .push_ok   (push_ok),
    .push_fire (push_fire),
    .pop_fire  (pop_fire),
    .head_data (rd_data),
    .level     (fill_level),
    .level_nxt (level_nxt),
    .is_empty  (empty)
  );

  rxq_idle_tmr #(.TMR_W(TMR_W)) tmr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .activity   (push_fire || pop_fire),
    .occupied   (!empty),
    .hold_clear (level_nxt == '0),
    .reload     (idle_reload),
    .expire     (expire)
  );

  rxq_irq_ctrl #(.DEPTH(DEPTH)) irq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .thr_sel   (thr_sel),
    .level_nxt (level_nxt),
    .expire    (expire),
    .irq       (rx_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ovr_q <= 1'b0;
    else if (rx_valid && !push_fire) ovr_q <= 1'b1;
    else if (ovr_clr)              ovr_q <= 1'b0;
  end

  assign overrun  = ovr_q;
  assign rx_ready = push_ok;
  assign rd_valid = !empty;
endmodule

// File: rtl/rxq_thresh_fifo_chk.sv
module rxq_thresh_fifo_chk #(
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             rd_ready,
  input logic             rx_ready,
  input logic             rd_valid,
  input logic [1:0]       thr_sel,
  input logic             ovr_clr,
  input logic [LVL_W-1:0] fill_level,
  input logic             empty,
  input logic             overrun,
  input logic             rx_irq
);
  logic full;
  assign full = (fill_level == LVL_W'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) fill_level <= LVL_W'(DEPTH)); // R1
  AST_IRQ_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fill_level) >= rxq_pkg::thr_value($past(thr_sel), DEPTH)) |-> rx_irq); // R2
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rx_irq |=> (rx_irq || empty)); // R3
  AST_IRQ_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rst_n) empty |-> !rx_irq); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full && !rd_ready) |=> ($stable(fill_level) && overrun)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (overrun && !ovr_clr) |=> overrun); // R8
  AST_SIMUL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rd_valid && rd_ready) |=> $stable(fill_level)); // R9
endmodule

bind rxq_thresh_fifo rxq_thresh_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_valid   (rx_valid),
  .rd_ready   (rd_ready),
  .rx_ready   (rx_ready),
  .rd_valid   (rd_valid),
  .thr_sel    (thr_sel),
  .ovr_clr    (ovr_clr),
  .fill_level (fill_level),
  .empty      (empty),
  .overrun    (overrun),
  .rx_irq     (rx_irq)
);

// File: tb/rxq_thresh_fifo_tb_top.sv
module rxq_thresh_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, rd_valid;
  logic        rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic [1:0]  thr_sel = 2'd0;
  logic [15:0] idle_reload = '0;
  logic        ovr_clr = 1'b0;
  logic [4:0]  fill_level;
  logic        empty, overrun, rx_irq;

  int tests = 0;
  int fails = 0;
  logic [7:0] model[$];

  always #2 clk = ~clk;

  rxq_thresh_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .thr_sel(thr_sel),
    .idle_reload(idle_reload), .ovr_clr(ovr_clr), .fill_level(fill_level), .empty(empty),
    .overrun(overrun), .rx_irq(rx_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("[TB] FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    if (model.size() < 16) model.push_back(b);
  endtask

  task automatic pop_chk(input string req);
    chk_eq({req, " head data"}, rd_data, model[0]);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    void'(model.pop_front());
    chk_eq({req, " level"}, fill_level, model.size());
  endtask

  task automatic drain(input string req);
    while (model.size() > 0) pop_chk(req);
    chk_eq({req, " empty after drain"}, empty, 1);
    chk_eq({req, " irq low after drain"}, rx_irq, 0);
  endtask

  task automatic t_reset;
    chk_eq("R1 reset level", fill_level, 0);
    chk_eq("R1 reset empty", empty, 1);
    chk_eq("R1 reset rx_ready", rx_ready, 1);
    chk_eq("R3 reset irq", rx_irq, 0);
    chk_eq("R8 reset overrun", overrun, 0);
  endtask

  task automatic t_threshold(input logic [1:0] sel, input int thr);
    thr_sel = sel;
    idle_reload = 16'd0;
    @(negedge clk);
    for (int i = 0; i < thr - 1; i++) begin
      push(8'(8'h30 + i));
      chk_eq("R2 below threshold irq low", rx_irq, 0);
    end
    push(8'hA5);
    chk_eq("R2 irq at threshold", rx_irq, 1);
    while (model.size() > 1) begin
      pop_chk("R3 drain");
      chk_eq("R3 irq held while draining", rx_irq, 1);
    end
    pop_chk("R3 last");
    chk_eq("R3 irq low at empty", rx_irq, 0);
    chk_eq("R1 empty at end", empty, 1);
  endtask

  task automatic t_single;
    thr_sel = 2'd0;
    idle_reload = 16'd0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      push(8'(8'h60 + i));
      chk_eq("R6 irq follows nonempty", rx_irq, !empty);
      chk_eq("R6 irq high", rx_irq, 1);
    end
    pop_chk("R6 read");
    chk_eq("R6 irq still high", rx_irq, 1);
    drain("R6");
  endtask

  task automatic t_idle;
    thr_sel = 2'd3;
    idle_reload = 16'd20;
    @(negedge clk);
    push(8'h11);
    push(8'h22);
    repeat (19) @(negedge clk);
    chk_eq("R4 irq low before timeout", rx_irq, 0);
    @(negedge clk);
    chk_eq("R4 irq at timeout", rx_irq, 1);
    repeat (30) @(negedge clk);
    chk_eq("R3 timeout irq held", rx_irq, 1);
    pop_chk("R4 read");
    chk_eq("R3 irq held after read", rx_irq, 1);
    drain("R4");
    repeat (40) @(negedge clk);
    chk_eq("R5 no timeout while empty", rx_irq, 0);
    for (int i = 0; i < 5; i++) begin
      push(8'(8'h70 + i));
      repeat (15) @(negedge clk);
      chk_eq("R4 reload by writes keeps irq low", rx_irq, 0);
    end
    drain("R4 reload");
    idle_reload = 16'd0;
    push(8'h55);
    repeat (100) @(negedge clk);
    chk_eq("R5 reload zero disables timeout", rx_irq, 0);
    drain("R5");
  endtask

  task automatic t_overrun;
    thr_sel = 2'd3;
    idle_reload = 16'd0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) push(8'(8'h80 + i));
    chk_eq("R1 full level", fill_level, 16);
    chk_eq("R1 rx_ready low when full", rx_ready, 0);
    chk_eq("R7 no overrun yet", overrun, 0);
    push(8'hEE);
    chk_eq("R7 level unchanged on drop", fill_level, 16);
    chk_eq("R7 overrun set", overrun, 1);
    rx_valid = 1'b1; rx_data = 8'hEF; ovr_clr = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; ovr_clr = 1'b0;
    chk_eq("R8 set wins over clear", overrun, 1);
    repeat (3) @(negedge clk);
    chk_eq("R8 overrun sticky", overrun, 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk_eq("R8 overrun cleared", overrun, 0);
    drain("R7 contents intact");
  endtask

  task automatic t_simul;
    thr_sel = 2'd3;
    idle_reload = 16'd0;
    @(negedge clk);
    push(8'h01); push(8'h02); push(8'h03);
    chk_eq("R9 head before", rd_data, 8'h01);
    rx_valid = 1'b1; rx_data = 8'h04; rd_ready = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rd_ready = 1'b0;
    void'(model.pop_front()); model.push_back(8'h04);
    chk_eq("R9 level unchanged", fill_level, 3);
    chk_eq("R9 head advanced", rd_data, 8'h02);
    for (int i = 0; i < 13; i++) push(8'(8'hC0 + i));
    chk_eq("R9 full", fill_level, 16);
    rd_ready = 1'b1;
    #1;
    chk_eq("R9 rx_ready with read when full", rx_ready, 1);
    rx_valid = 1'b1; rx_data = 8'hDD;
    @(negedge clk);
    rx_valid = 1'b0; rd_ready = 1'b0;
    void'(model.pop_front()); model.push_back(8'hDD);
    chk_eq("R9 full level kept", fill_level, 16);
    chk_eq("R9 no overrun with read", overrun, 0);
    drain("R9 order");
  endtask

  task automatic t_thr_change;
    thr_sel = 2'd1;
    idle_reload = 16'd0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) push(8'(8'h40 + i));
    chk_eq("R10 irq up", rx_irq, 1);
    thr_sel = 2'd3;
    repeat (2) @(negedge clk);
    chk_eq("R10 irq kept after threshold raise", rx_irq, 1);
    pop_chk("R10 read");
    chk_eq("R10 irq kept below new threshold", rx_irq, 1);
    drain("R10");
  endtask

  task automatic t_head;
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    chk_eq("R11 read while empty level", fill_level, 0);
    chk_eq("R11 read while empty flag", empty, 1);
    push(8'h9C);
    chk_eq("R11 head visible at once", rd_data, 8'h9C);
    chk_eq("R11 rd_valid", rd_valid, 1);
    drain("R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold(2'd1, 4);
    t_threshold(2'd2, 8);
    t_threshold(2'd3, 14);
    t_single();
    t_idle();
    t_overrun();
    t_simul();
    t_thr_change();
    t_head();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("[TB] FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule